// File: doc/BRIEF.md
# Quadrature Clock and Reset Generator

This block turns one fast oscillator into the timing base of a small system. A two-bit counter divides the oscillator by four and gives two clock phases of equal period. The second phase trails the first by one oscillator cycle, which is a quarter of their period. Logic downstream can combine the two to mark any quarter of a cycle.

The block also builds the system reset. A supervisor stretches any reset request into a long hold. Three things raise a request: a power-good input that goes low, a push-button that stays pressed past a debounce window, and a watchdog that sees its strobe stop toggling. Loss of power pulls the reset low at once. Every other change of the reset output takes effect only on an oscillator edge at which the primary phase rises, so downstream flops see it change only on their own clock edge. The hold time, the debounce window and the watchdog timeout are parameters counted in oscillator cycles, so a simulation can shorten them.

Top module: `qclk_gen`

## Requirements
- R1: While `pwr_ok` is high, `ph0` repeats high for 2 oscillator cycles and then low for 2 (a period of 4 cycles). The first oscillator edge after `pwr_ok` rises drives `ph0` high.
- R2: `ph1` always equals the value `ph0` had one oscillator cycle earlier, so it lags `ph0` by a quarter period.
- R3: While `pwr_ok` is low, `rst_n`, `ph0` and `ph1` are all 0. This takes effect immediately, with no clock edge needed.
- R4: After `pwr_ok` rises, including after a glitch shorter than one cycle, `rst_n` stays low for at least HOLD_CYC oscillator edges. It goes high on the first `ph0` rising edge at which the hold count has run out, which is no later than edge HOLD_CYC+4.
- R5: Apart from the R3 case, `rst_n` changes only on an oscillator edge at which `ph0` goes from 0 to 1.
- R6: If `btn_n` (active low, idle high) is held low for longer than DEB_CYC cycles plus the two-stage synchroniser, `rst_n` falls. After release, `rst_n` stays low for at least another DEB_CYC+HOLD_CYC cycles.
- R7: A low pulse on `btn_n` shorter than DEB_CYC cycles has no effect: `rst_n` stays high.
- R8: If `wd_strobe` changes level at least once every WDOG_CYC cycles, no reset occurs. Tying `wd_strobe` to `ph0` keeps the watchdog from ever firing.
- R9: If `wd_strobe` stays at one level for WDOG_CYC cycles while reset is released, `rst_n` falls. It rises again HOLD_CYC cycles later, on the `ph0` grid.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator, four times the output clock rate |
| pwr_ok | input | 1 | Power-good level; low clears the block asynchronously |
| btn_n | input | 1 | Reset push-button, active low, idle high |
| wd_strobe | input | 1 | Watchdog keep-alive; any level change counts |
| ph0 | output | 1 | Primary clock phase at one quarter of the oscillator rate |
| ph1 | output | 1 | Second phase, one oscillator cycle behind ph0 |
| rst_n | output | 1 | Active-low system reset, re-timed to ph0 |

## Verification
Each result falls due at a fixed number of cycles after its cause:
- The phases move on every oscillator edge.
- Release after power-up arrives between edge HOLD_CYC+1 and HOLD_CYC+4. The exact edge depends on where the `ph0` rising edge falls.
- A button press lands about two synchroniser cycles plus DEB_CYC cycles later, rounded up to the next `ph0` rising edge.
- A watchdog trip lands three cycles plus WDOG_CYC cycles after the last strobe change, again rounded to `ph0`.

For every stimulus, a driver pushes into a queue the expected reset edge and the window of negative-edge cycle numbers that covers that rounding. A monitor then compares each observed `rst_n` edge against the window at the head of the queue. All sampling happens on the falling oscillator edge. Any reset edge that has no queued entry counts as a failure.

// File: rtl/qclk_pkg.sv
package qclk_pkg;

    // Two-bit Johnson state: bit 1 drives ph0, bit 0 drives ph1.
    typedef enum logic [1:0] {
        QPH_LOW  = 2'b00,
        QPH_LEAD = 2'b10,
        QPH_HIGH = 2'b11,
        QPH_TAIL = 2'b01
    } quad_phase_e;

    // Next Johnson state: shift ph0 into ph1, feed back inverted ph1.
    function automatic quad_phase_e quad_step(input quad_phase_e cur);
        logic [1:0] bits;
        bits = cur;
        return quad_phase_e'({~bits[0], bits[1]});
    endfunction

    localparam int QCLK_DIVIDE = 4;

endpackage

// File: rtl/qclk_divider.sv
module qclk_divider
    import qclk_pkg::*;
(
    input  logic osc_clk,
    input  logic arst_n,
    output logic ph0,
    output logic ph1,
    output logic rise_next
);

    typedef struct packed {
        quad_phase_e phase;
    } div_state_t;

    div_state_t st_d;
    div_state_t st_q;
    logic [1:0] ph_bits;

    always_comb begin
        st_d       = st_q;
        st_d.phase = quad_step(st_q.phase);
    end

    always_ff @(posedge osc_clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{phase: QPH_LOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_bits   = st_q.phase;
    assign ph0       = ph_bits[1];
    assign ph1       = ph_bits[0];
    // The coming edge moves the state from LOW to LEAD, so ph0 rises on it.
    assign rise_next = (st_q.phase == QPH_LOW);

endmodule

// File: rtl/qclk_debounce.sv
module qclk_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 8
) (
    input  logic osc_clk,
    input  logic arst_n,
    input  logic raw_n,
    output logic level_o
);

    localparam int CW = $clog2(STABLE_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   level;
    } deb_state_t;

    deb_state_t             st_d;
    deb_state_t             st_q;
    logic [SYNC_STAGES-1:0] shifted;
    logic                   sampled;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign shifted = {st_q.sync[SYNC_STAGES-2:0], raw_n};
        end else begin : g_single
            assign shifted = raw_n;
        end
    endgenerate

    assign sampled = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = shifted;
        if (sampled == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(STABLE_CYC - 1)) begin
            st_d.level = sampled;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge osc_clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{sync: '1, cnt: '0, level: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/qclk_watchdog.sv
module qclk_watchdog #(
    parameter int SYNC_STAGES = 2,
    parameter int WDOG_CYC    = 64
) (
    input  logic osc_clk,
    input  logic arst_n,
    input  logic strobe,
    input  logic hold_active,
    output logic bite
);

    localparam int CW = $clog2(WDOG_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [CW-1:0]          cnt;
        logic                   bite;
    } wd_state_t;

    wd_state_t              st_d;
    wd_state_t              st_q;
    logic [SYNC_STAGES-1:0] shifted;
    logic                   toggled;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            assign shifted = {st_q.sync[SYNC_STAGES-2:0], strobe};
        end else begin : g_single
            assign shifted = strobe;
        end
    endgenerate

    assign toggled = st_q.sync[SYNC_STAGES-1] ^ st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = shifted;
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        st_d.bite = 1'b0;
        if (hold_active || toggled) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(WDOG_CYC - 1)) begin
            st_d.cnt  = '0;
            st_d.bite = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge osc_clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{sync: '0, prev: 1'b0, cnt: '0, bite: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bite = st_q.bite;

endmodule

// File: rtl/qclk_hold.sv
module qclk_hold #(
    parameter int HOLD_CYC = 40
) (
    input  logic osc_clk,
    input  logic arst_n,
    input  logic trigger,
    output logic idle
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_state_t;

    hold_state_t st_d;
    hold_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (trigger) begin
            st_d.cnt = CW'(HOLD_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    // Power loss loads a full hold, so release always waits the whole count.
    always_ff @(posedge osc_clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{cnt: CW'(HOLD_CYC)};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = (st_q.cnt == '0);

endmodule

// File: rtl/qclk_gen.sv
module qclk_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 1_250_000,
    parameter int HOLD_CYC    = 12_500_000,
    parameter int WDOG_CYC    = 125_000_000
) (
    input  logic osc_clk,
    input  logic pwr_ok,
    input  logic btn_n,
    input  logic wd_strobe,
    output logic ph0,
    output logic ph1,
    output logic rst_n
);

    typedef struct packed {
        logic rst_n;
    } out_state_t;

    logic       rise_next;
    logic       btn_lvl;
    logic       wd_bite;
    logic       hold_idle;
    logic       hold_trig;
    out_state_t st_d;
    out_state_t st_q;

    qclk_divider u_div (
        .osc_clk   (osc_clk),
        .arst_n    (pwr_ok),
        .ph0       (ph0),
        .ph1       (ph1),
        .rise_next (rise_next)
    );

    qclk_debounce #(
        .SYNC_STAGES (SYNC_STAGES),
        .STABLE_CYC  (DEB_CYC)
    ) u_btn (
        .osc_clk (osc_clk),
        .arst_n  (pwr_ok),
        .raw_n   (btn_n),
        .level_o (btn_lvl)
    );

    qclk_watchdog #(
        .SYNC_STAGES (SYNC_STAGES),
        .WDOG_CYC    (WDOG_CYC)
    ) u_wd (
        .osc_clk     (osc_clk),
        .arst_n      (pwr_ok),
        .strobe      (wd_strobe),
        .hold_active (~hold_idle),
        .bite        (wd_bite)
    );

    assign hold_trig = ~btn_lvl | wd_bite;

    qclk_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .osc_clk (osc_clk),
        .arst_n  (pwr_ok),
        .trigger (hold_trig),
        .idle    (hold_idle)
    );

    // Output reset only updates on the edge that raises ph0.
    always_comb begin
        st_d = st_q;
        if (rise_next) begin
            st_d.rst_n = hold_idle;
        end
    end

    always_ff @(posedge osc_clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            st_q <= '{rst_n: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n = st_q.rst_n;

endmodule

// File: rtl/qclk_gen_chk.sv
module qclk_gen_chk #(
    parameter int DEB_CYC = 8
) (
    input logic osc_clk,
    input logic pwr_ok,
    input logic btn_n,
    input logic ph0,
    input logic ph1,
    input logic rst_n,
    input logic btn_lvl,
    input logic wd_bite,
    input logic hold_idle
);

    logic settled_q;
    int   low_run_q;

    always_ff @(posedge osc_clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            settled_q <= 1'b0;
        end else begin
            settled_q <= 1'b1;
        end
    end

    always_ff @(posedge osc_clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            low_run_q <= 0;
        end else if (btn_n) begin
            low_run_q <= 0;
        end else if (low_run_q < DEB_CYC + 16) begin
            low_run_q <= low_run_q + 1;
        end
    end

    assert_ph0_high_two_R1: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        $rose(ph0) |=> ph0);

    assert_ph0_low_after_two_R1: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        (ph0 && $past(ph0)) |=> !ph0);

    assert_ph1_lags_R2: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        ph1 == $past(ph0));

    assert_power_loss_R3: assert property (@(negedge osc_clk)
        !pwr_ok |-> (!rst_n && !ph0 && !ph1));

    assert_release_after_hold_R4: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        $rose(rst_n) |-> $past(hold_idle));

    assert_edge_on_ph0_R5: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        !$stable(rst_n) |-> $rose(ph0));

    assert_button_holds_R6: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        !btn_lvl |=> !hold_idle);

    assert_short_press_ignored_R7: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        $fell(btn_lvl) |-> (low_run_q >= DEB_CYC));

    assert_bite_reloads_R9: assert property (@(posedge osc_clk) disable iff (!pwr_ok || !settled_q)
        wd_bite |=> !hold_idle);

endmodule

bind qclk_gen qclk_gen_chk #(.DEB_CYC(DEB_CYC)) u_chk (
    .osc_clk   (osc_clk),
    .pwr_ok    (pwr_ok),
    .btn_n     (btn_n),
    .ph0       (ph0),
    .ph1       (ph1),
    .rst_n     (rst_n),
    .btn_lvl   (btn_lvl),
    .wd_bite   (wd_bite),
    .hold_idle (hold_idle)
);

// File: tb/tb_qclk_gen.sv
module tb_qclk_gen;

    localparam int S = 2;
    localparam int D = 8;
    localparam int H = 40;
    localparam int W = 64;

    logic osc_clk = 1'b0;
    logic pwr_ok;
    logic btn_n;
    logic strobe_r;
    logic tie;
    logic ph0;
    logic ph1;
    logic rst_n;
    logic wd_strobe;

    assign wd_strobe = tie ? ph0 : strobe_r;

    qclk_gen #(
        .SYNC_STAGES (S),
        .DEB_CYC     (D),
        .HOLD_CYC    (H),
        .WDOG_CYC    (W)
    ) dut (
        .osc_clk   (osc_clk),
        .pwr_ok    (pwr_ok),
        .btn_n     (btn_n),
        .wd_strobe (wd_strobe),
        .ph0       (ph0),
        .ph1       (ph1),
        .rst_n     (rst_n)
    );

    always #4 osc_clk = ~osc_clk;

    typedef struct {
        bit    rise;
        int    lo;
        int    hi;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   pwr_drops = 0;
    int   last_edge = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_edge(input bit rise, input int lo, input int hi, input string req);
        exp_t e;
        e.rise = rise;
        e.lo   = lo;
        e.hi   = hi;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic sync_neg();
        @(negedge osc_clk);
        #1;
    endtask

    task automatic wait_drain(input int limit);
        int n = 0;
        while (q.size() != 0 && n < limit) begin
            sync_neg();
            n++;
        end
    endtask

    always @(negedge pwr_ok) pwr_drops++;

    // Monitor: samples on the falling edge, checks phases and reset edges.
    logic prev_rst = 1'b0;
    logic prev_ph0 = 1'b0;
    int   last_rise = -1;
    int   seen_drops = 0;

    always @(negedge osc_clk) begin
        bit skip;
        cyc++;
        skip = (seen_drops != pwr_drops) || !pwr_ok;
        seen_drops = pwr_drops;
        if (skip) last_rise = -1;
        if (!skip) begin
            check(ph1 == prev_ph0, "R2", "ph1 vs previous ph0", int'(ph1), int'(prev_ph0));
            if (ph0 && !prev_ph0) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == 4, "R1", "ph0 period", cyc - last_rise, 4);
                last_rise = cyc;
            end
        end
        if (rst_n !== prev_rst) begin
            last_edge = cyc;
            if (!skip)
                check(ph0 && !prev_ph0, "R5", "rst_n edge without ph0 rise", int'(ph0), 1);
            if (q.size() == 0) begin
                check(1'b0, "R7/R8", "unexpected rst_n edge at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.rise == rst_n, e.req, "rst_n edge direction", int'(rst_n), int'(e.rise));
                check(cyc >= e.lo && cyc <= e.hi, e.req, "rst_n edge cycle (lo bound shown)", cyc, e.lo);
            end
        end
        prev_rst = rst_n;
        prev_ph0 = ph0;
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge osc_clk);
        check(1'b0, "R4", "watchdog timeout at cycle", cyc, 20000);
        finish_run();
    end

    initial begin
        int c;
        int r;
        int t;
        int f;
        pwr_ok   = 1'b1;
        btn_n    = 1'b1;
        strobe_r = 1'b0;
        tie      = 1'b1;
        #2 pwr_ok = 1'b0;
        #1;
        check(rst_n == 1'b0, "R3", "rst_n right after power loss", int'(rst_n), 0);
        repeat (5) sync_neg();
        check(rst_n == 1'b0, "R3", "rst_n while power bad", int'(rst_n), 0);
        check(ph0 == 1'b0 && ph1 == 1'b0, "R3", "phases while power bad", int'({ph0, ph1}), 0);

        // Power-up: release between edge H+1 and H+4 (R4).
        c = cyc;
        expect_edge(1'b1, c + H + 1, c + H + 4, "R4");
        pwr_ok = 1'b1;
        wait_drain(H + 20);
        check(rst_n == 1'b1, "R4", "rst_n after power-up hold", int'(rst_n), 1);

        // Strobe tied to ph0: the watchdog never fires (R8).
        repeat (3 * W) sync_neg();
        check(rst_n == 1'b1, "R8", "rst_n with strobe tied to ph0", int'(rst_n), 1);

        // Short button glitch is ignored (R7).
        btn_n = 1'b0;
        repeat (D - 3) sync_neg();
        btn_n = 1'b1;
        repeat (100) sync_neg();
        check(rst_n == 1'b1, "R7", "rst_n after short press", int'(rst_n), 1);

        // Long press: reset after debounce, held after release (R6).
        c = cyc;
        expect_edge(1'b0, c + D, c + D + S + 6, "R6");
        btn_n = 1'b0;
        repeat (30) sync_neg();
        check(rst_n == 1'b0, "R6", "rst_n during long press", int'(rst_n), 0);
        r = cyc;
        expect_edge(1'b1, r + D + H, r + D + H + S + 6, "R6");
        btn_n = 1'b1;
        wait_drain(D + H + 30);
        check(rst_n == 1'b1, "R6", "rst_n after press released", int'(rst_n), 1);

        // Manual strobe toggled well inside the timeout (R8).
        tie = 1'b0;
        for (int i = 0; i < 15; i++) begin
            repeat (20) sync_neg();
            strobe_r = ~strobe_r;
        end
        check(rst_n == 1'b1, "R8", "rst_n with regular strobe", int'(rst_n), 1);

        // Strobe stops: watchdog trips, reset held H cycles (R9).
        t = cyc;
        expect_edge(1'b0, t + W, t + W + S + 8, "R9");
        wait_drain(W + 30);
        f = last_edge;
        expect_edge(1'b1, f + H - 4, f + H + 4, "R9");
        tie = 1'b1;
        wait_drain(H + 20);
        check(rst_n == 1'b1, "R9", "rst_n after watchdog hold", int'(rst_n), 1);

        // Sub-cycle power glitch: immediate reset, then a full hold (R3, R4).
        sync_neg();
        c = cyc;
        expect_edge(1'b0, c + 1, c + 1, "R3");
        expect_edge(1'b1, c + H + 2, c + H + 5, "R4");
        #4 pwr_ok = 1'b0;
        #1;
        check(rst_n == 1'b0 && ph0 == 1'b0 && ph1 == 1'b0, "R3", "outputs during power glitch",
              int'({rst_n, ph0, ph1}), 0);
        #1 pwr_ok = 1'b1;
        wait_drain(H + 20);
        check(rst_n == 1'b1, "R4", "rst_n after power glitch hold", int'(rst_n), 1);

        repeat (20) sync_neg();
        check(q.size() == 0, "R5", "pending expected edges", q.size(), 0);
        finish_run();
    end

endmodule